// File: doc/BRIEF.md
# Vectored Interrupt Mapping Controller

This block collects 64 level-sensitive interrupt lines and turns them into a single outstanding request, shown as a one-hot vector toward the processor. Lines 0 to 31 belong to expansion slots and share an enable register per group of four lines. Lines 32 to 63 belong to on-board devices, and each has its own enable register. An enable register carries one enable bit, bit 31. Its lower 31 bits are a fixed identity code that software can read.

Software reaches the enable registers and the retire registers through a simple 32-bit register bus. Writing a retire register that matches the held request frees the block. Clearing the enable bit of the register that owns the held request also frees it. In both cases the block waits one cycle and then scans the pending lines again. If a pending line is enabled, it becomes the next request without further software action.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Line n < 32 is enabled by bit 31 of slot enable register n>>2. Line n >= 32 is enabled by bit 31 of board enable register n-32. A rising edge on a line that is not enabled never creates a request.
- R2: Slot enable register k (k = 0..7) sits at address 0x0C00+8k and board enable register k (k = 0..31) at 0x1000+8k. Read data appears on busRdData in the cycle after busRdEn.
- R3: At most one request is held. vecOut is all zero or has exactly the bit of the held line set, and the held bit stays set until the request is retired, even when the line falls.
- R4: A write to an enable register changes only bit 31. The low 31 bits always read back as 0x7C0|(k<<2) for slot register k and 0x7E0+k for board register k.
- R5: A slot line rising while enabled becomes the request in the next cycle, even when another request is held. Among slot lines that rise in the same cycle, the lowest number wins.
- R6: A board line rising while enabled becomes the request only if no request is held.
- R7: A write anywhere in 0x1400-0x14FF retires the request when the held line number divided by 4 equals (address & 0xFF)>>5. A write to 0x1800+8k retires the request when the held line is 32+k. A write that does not match leaves the request unchanged.
- R8: A write with bit 31 clear to the enable register that owns the held line retires the request. For slot register k the held line must be below 32 with line>>2 = k. For board register k the held line must be 32+k.
- R9: After a retire, vecOut is zero for one cycle. Then the lowest-numbered line that is high and enabled becomes the request, slot lines before board lines. If no such line exists, the block stays idle.
- R10: Reset clears every enable bit, the sampled line levels and the held request, so vecOut is zero.
- R11: Reads from any other address return zero, and writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| irqIn | input | 64 | Level interrupt lines, slots 0-31, board 32-63 |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe |
| busAddr | input | 16 | Register byte address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, valid the cycle after busRdEn |
| vecOut | output | 64 | One-hot vector of the held request |

## Verification
The bench builds the block with its default parameters: 32 slot lines in groups of four, 32 board lines and a 16-bit address. With these values the shared group enables and the per-line board enables can both be tested, as can the group-wide retire and the exact board retire, and the full 64-line priority order. The directed scenarios cover several things: preemption by a slot line, a board line held back while a request is pending, a rescan that finds a slot line before a lower-addressed board line, and a rescan that finds nothing.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 8;

  // Strobes from control to datapath
  typedef struct packed {
    logic              slotMapWr;
    logic              boardMapWr;
    logic              slotMapRd;
    logic              boardMapRd;
    logic [IDX_W-1:0]  mapIdx;
    logic              newValid;
  } mapStrobe_t;
endpackage

// File: rtl/ivc_prio_enc.sv
module ivc_prio_enc #(
  parameter int W = 8,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  req,
  output logic          hit,
  output logic [IW-1:0] idx
);
  // Lowest set bit wins
  always_comb begin
    hit = |req;
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/ivc_datapath.sv
module ivc_datapath
  import ivc_pkg::*;
#(
  parameter int NUM_SLOT   = 32,
  parameter int NUM_BOARD  = 32,
  parameter int SLOT_SHARE = 4,
  localparam int NUM_SRC   = NUM_SLOT + NUM_BOARD,
  localparam int ID_W      = $clog2(NUM_SRC),
  localparam int SLOT_W    = $clog2(NUM_SLOT),
  localparam int BOARD_W   = $clog2(NUM_BOARD),
  localparam int NUM_SMAP  = NUM_SLOT / SLOT_SHARE,
  localparam int SMAP_W    = (NUM_SMAP > 1) ? $clog2(NUM_SMAP) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  mapStrobe_t         strobe,
  input  logic [NUM_SRC-1:0] irqIn,
  output logic [DATA_W-1:0]  rdData,
  output logic               scanHit,
  output logic [ID_W-1:0]    scanId,
  output logic               slotRiseHit,
  output logic [SLOT_W-1:0]  slotRiseId,
  output logic               boardRiseHit,
  output logic [BOARD_W-1:0] boardRiseId
);
  logic [NUM_SMAP-1:0]  slotValidQ;
  logic [NUM_BOARD-1:0] boardValidQ;
  logic [NUM_SRC-1:0]   levelQ;
  logic [NUM_SRC-1:0]   srcEn;
  logic [NUM_SRC-1:0]   riseVec;
  logic [NUM_SRC-1:0]   pendVec;
  logic [SMAP_W-1:0]    slotIdx;
  logic [BOARD_W-1:0]   boardIdx;
  logic                 unusedIdxBits;

  assign slotIdx       = strobe.mapIdx[SMAP_W-1:0];
  assign boardIdx      = strobe.mapIdx[BOARD_W-1:0];
  assign unusedIdxBits = ^strobe.mapIdx;

  // Fixed identity codes held in the low 31 bits
  function automatic logic [DATA_W-2:0] slotCode(input logic [SMAP_W-1:0] k);
    return (DATA_W-1)'(32'h7C0 | (32'(k) << 2));
  endfunction

  function automatic logic [DATA_W-2:0] boardCode(input logic [BOARD_W-1:0] k);
    return (DATA_W-1)'(32'h7E0 + 32'(k));
  endfunction

  for (genvar n = 0; n < NUM_SLOT; n++) begin : g_slotEn
    assign srcEn[n] = slotValidQ[n / SLOT_SHARE];
  end
  for (genvar n = 0; n < NUM_BOARD; n++) begin : g_boardEn
    assign srcEn[NUM_SLOT + n] = boardValidQ[n];
  end

  assign riseVec = irqIn & ~levelQ & srcEn;
  assign pendVec = levelQ & srcEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotValidQ  <= '0;
      boardValidQ <= '0;
      levelQ      <= '0;
      rdData      <= '0;
    end else begin
      levelQ <= irqIn;
      if (strobe.slotMapWr)  slotValidQ[slotIdx]   <= strobe.newValid;
      if (strobe.boardMapWr) boardValidQ[boardIdx] <= strobe.newValid;
      if (strobe.slotMapRd)
        rdData <= {slotValidQ[slotIdx], slotCode(slotIdx)};
      else if (strobe.boardMapRd)
        rdData <= {boardValidQ[boardIdx], boardCode(boardIdx)};
      else
        rdData <= '0;
    end
  end

  ivc_prio_enc #(.W(NUM_SRC)) u_scanEnc (
    .req(pendVec), .hit(scanHit), .idx(scanId)
  );
  ivc_prio_enc #(.W(NUM_SLOT)) u_slotRiseEnc (
    .req(riseVec[NUM_SLOT-1:0]), .hit(slotRiseHit), .idx(slotRiseId)
  );
  ivc_prio_enc #(.W(NUM_BOARD)) u_boardRiseEnc (
    .req(riseVec[NUM_SRC-1:NUM_SLOT]), .hit(boardRiseHit), .idx(boardRiseId)
  );
endmodule

// File: rtl/ivc_ctrl.sv
module ivc_ctrl
  import ivc_pkg::*;
#(
  parameter int NUM_SLOT        = 32,
  parameter int NUM_BOARD       = 32,
  parameter int SLOT_SHARE      = 4,
  parameter int ADDR_W          = 16,
  parameter int SLOT_MAP_BASE   = 'h0C00,
  parameter int BOARD_MAP_BASE  = 'h1000,
  parameter int SLOT_CLR_BASE   = 'h1400,
  parameter int BOARD_CLR_BASE  = 'h1800,
  parameter int REG_STRIDE      = 8,
  parameter int GROUP_STRIDE    = 32,
  localparam int NUM_SRC        = NUM_SLOT + NUM_BOARD,
  localparam int ID_W           = $clog2(NUM_SRC),
  localparam int SLOT_W         = $clog2(NUM_SLOT),
  localparam int BOARD_W        = $clog2(NUM_BOARD),
  localparam int NUM_SMAP       = NUM_SLOT / SLOT_SHARE,
  localparam int SMAP_SPAN      = NUM_SMAP * REG_STRIDE,
  localparam int BMAP_SPAN      = NUM_BOARD * REG_STRIDE,
  localparam int SCLR_SPAN      = NUM_SMAP * GROUP_STRIDE
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrEn,
  input  logic               busRdEn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               wrValidBit,
  input  logic               scanHit,
  input  logic [ID_W-1:0]    scanId,
  input  logic               slotRiseHit,
  input  logic [SLOT_W-1:0]  slotRiseId,
  input  logic               boardRiseHit,
  input  logic [BOARD_W-1:0] boardRiseId,
  output mapStrobe_t         strobe,
  output logic [NUM_SRC-1:0] vecOut
);
  logic [31:0]     addr32;
  logic            slotMapHit, boardMapHit, slotClrHit, boardClrHit;
  logic [31:0]     slotGrp, boardClrNum, slotMapNum, boardMapNum, reqNum;
  logic            clrRetire, dropRetire;
  logic            reqValidQ, scanPendQ;
  logic [ID_W-1:0] reqIdQ;

  assign addr32 = 32'(busAddr);

  // Address decode
  assign slotMapHit  = (addr32 >= SLOT_MAP_BASE)  && (addr32 < SLOT_MAP_BASE + SMAP_SPAN);
  assign boardMapHit = (addr32 >= BOARD_MAP_BASE) && (addr32 < BOARD_MAP_BASE + BMAP_SPAN);
  assign slotClrHit  = (addr32 >= SLOT_CLR_BASE)  && (addr32 < SLOT_CLR_BASE + SCLR_SPAN);
  assign boardClrHit = (addr32 >= BOARD_CLR_BASE) && (addr32 < BOARD_CLR_BASE + BMAP_SPAN);

  assign slotMapNum  = (addr32 - SLOT_MAP_BASE)  / REG_STRIDE;
  assign boardMapNum = (addr32 - BOARD_MAP_BASE) / REG_STRIDE;
  assign slotGrp     = (addr32 - SLOT_CLR_BASE)  / GROUP_STRIDE;
  assign boardClrNum = (addr32 - BOARD_CLR_BASE) / REG_STRIDE;
  assign reqNum      = 32'(reqIdQ);

  // Strobes to the datapath
  always_comb begin
    strobe            = '0;
    strobe.slotMapWr  = busWrEn && slotMapHit;
    strobe.boardMapWr = busWrEn && boardMapHit;
    strobe.slotMapRd  = busRdEn && slotMapHit;
    strobe.boardMapRd = busRdEn && boardMapHit;
    strobe.newValid   = wrValidBit;
    strobe.mapIdx     = slotMapHit ? IDX_W'(slotMapNum) : IDX_W'(boardMapNum);
  end

  // Retire conditions
  always_comb begin
    clrRetire  = 1'b0;
    dropRetire = 1'b0;
    if (busWrEn && reqValidQ) begin
      if (slotClrHit && (reqNum / SLOT_SHARE) == slotGrp)
        clrRetire = 1'b1;
      if (boardClrHit && reqNum == NUM_SLOT + boardClrNum)
        clrRetire = 1'b1;
      if (!wrValidBit && slotMapHit && reqNum < NUM_SLOT &&
          (reqNum / SLOT_SHARE) == slotMapNum)
        dropRetire = 1'b1;
      if (!wrValidBit && boardMapHit && reqNum == NUM_SLOT + boardMapNum)
        dropRetire = 1'b1;
    end
  end

  // Held request
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqValidQ <= 1'b0;
      reqIdQ    <= '0;
      scanPendQ <= 1'b0;
    end else if (clrRetire || dropRetire) begin
      reqValidQ <= 1'b0;
      scanPendQ <= 1'b1;
    end else if (scanPendQ && scanHit) begin
      reqValidQ <= 1'b1;
      reqIdQ    <= scanId;
      scanPendQ <= 1'b0;
    end else begin
      scanPendQ <= 1'b0;
      if (slotRiseHit) begin
        reqValidQ <= 1'b1;
        reqIdQ    <= ID_W'(slotRiseId);
      end else if (boardRiseHit && !reqValidQ) begin
        reqValidQ <= 1'b1;
        reqIdQ    <= ID_W'(NUM_SLOT) + ID_W'(boardRiseId);
      end
    end
  end

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_vec
    assign vecOut[n] = reqValidQ && (reqIdQ == ID_W'(n));
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import ivc_pkg::*;
#(
  parameter int NUM_SLOT   = 32,
  parameter int NUM_BOARD  = 32,
  parameter int SLOT_SHARE = 4,
  parameter int ADDR_W     = 16,
  localparam int NUM_SRC   = NUM_SLOT + NUM_BOARD,
  localparam int ID_W      = $clog2(NUM_SRC),
  localparam int SLOT_W    = $clog2(NUM_SLOT),
  localparam int BOARD_W   = $clog2(NUM_BOARD)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic               busWrEn,
  input  logic               busRdEn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWrData,
  output logic [DATA_W-1:0]  busRdData,
  output logic [NUM_SRC-1:0] vecOut
);
  mapStrobe_t         strobe;
  logic               scanHit, slotRiseHit, boardRiseHit;
  logic [ID_W-1:0]    scanId;
  logic [SLOT_W-1:0]  slotRiseId;
  logic [BOARD_W-1:0] boardRiseId;
  logic               unusedWrBits;

  assign unusedWrBits = ^busWrData[DATA_W-2:0];

  ivc_ctrl #(
    .NUM_SLOT(NUM_SLOT), .NUM_BOARD(NUM_BOARD),
    .SLOT_SHARE(SLOT_SHARE), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .wrValidBit(busWrData[DATA_W-1]),
    .scanHit(scanHit), .scanId(scanId),
    .slotRiseHit(slotRiseHit), .slotRiseId(slotRiseId),
    .boardRiseHit(boardRiseHit), .boardRiseId(boardRiseId),
    .strobe(strobe), .vecOut(vecOut)
  );

  ivc_datapath #(
    .NUM_SLOT(NUM_SLOT), .NUM_BOARD(NUM_BOARD), .SLOT_SHARE(SLOT_SHARE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .irqIn(irqIn),
    .rdData(busRdData),
    .scanHit(scanHit), .scanId(scanId),
    .slotRiseHit(slotRiseHit), .slotRiseId(slotRiseId),
    .boardRiseHit(boardRiseHit), .boardRiseId(boardRiseId)
  );
endmodule

// File: rtl/ivc_checker.sv
module ivc_checker #(
  parameter int NUM_SLOT  = 32,
  parameter int NUM_SRC   = 64,
  parameter int ADDR_W    = 16,
  localparam int ID_W     = $clog2(NUM_SRC)
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] irqIn,
  input logic               busWrEn,
  input logic               busRdEn,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [31:0]        busRdData,
  input logic [NUM_SRC-1:0] vecOut
);
  p_onehot_vec_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(vecOut));

  p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    (vecOut != '0 && !busWrEn && irqIn[NUM_SLOT-1:0] == '0) |=> $stable(vecOut));

  p_reset_idle_r10: assert property (@(posedge clk)
    !rstN |=> vecOut == '0);

  p_board_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr[15:8] == 8'h18 &&
     vecOut[ID_W'(NUM_SLOT) + ID_W'(busAddr[7:3])]) |=> vecOut == '0);

  p_unmapped_read_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr[15:12] == 4'hF) |=> busRdData == '0);
endmodule

bind irq_vector_ctrl ivc_checker #(
  .NUM_SLOT(NUM_SLOT), .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)
) u_ivcChecker (
  .clk(clk), .rstN(rstN), .irqIn(irqIn), .busWrEn(busWrEn),
  .busRdEn(busRdEn), .busAddr(busAddr), .busRdData(busRdData),
  .vecOut(vecOut)
);

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] irqIn = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [15:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [63:0] vecOut;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  irq_vector_ctrl dut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(busRdData), .vecOut(vecOut)
  );

  function automatic logic [63:0] bit64(input int n);
    return 64'(1) << n;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic busWrite(input logic [15:0] a, input logic [31:0] d);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0; busAddr = '0; busWrData = '0;
  endtask

  task automatic busRead(input logic [15:0] a, output logic [31:0] d);
    busRdEn = 1'b1; busAddr = a;
    @(negedge clk);
    busRdEn = 1'b0; busAddr = '0;
    d = busRdData;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R10 vec idle in reset", vecOut, 64'h0);
    rstN = 1'b1;
    tick(1);
    check("R10 vec idle after reset", vecOut, 64'h0);
    busRead(16'h0C18, d);
    check("R10/R4 slot map 3 reset value", 64'(d), 64'h7CC);
    busRead(16'h1028, d);
    check("R2 board map 5 reset value", 64'(d), 64'h7E5);
  endtask

  task automatic t_mapWrite;
    logic [31:0] d;
    busWrite(16'h0C10, 32'hFFFF_FFFF);
    busRead(16'h0C10, d);
    check("R4 slot map 2 only bit31 written", 64'(d), 64'h8000_07C8);
    busWrite(16'h10F8, 32'h8000_0000);
    busRead(16'h10F8, d);
    check("R4 board map 31 write", 64'(d), 64'h8000_07FF);
  endtask

  task automatic t_disabled;
    irqIn[20] = 1'b1;
    tick(2);
    check("R1 disabled slot line ignored", vecOut, 64'h0);
    irqIn[20] = 1'b0;
    tick(1);
  endtask

  task automatic t_slotRise;
    irqIn[9] = 1'b1;
    tick(1);
    check("R5 slot rise becomes request", vecOut, bit64(9));
    irqIn[9] = 1'b0;
    tick(3);
    check("R3 request held after line falls", vecOut, bit64(9));
  endtask

  task automatic t_boardHeldBack;
    irqIn[63] = 1'b1;
    tick(2);
    check("R6 board rise does not preempt", vecOut, bit64(9));
  endtask

  task automatic t_preempt;
    busWrite(16'h0C00, 32'h8000_0000);
    check("R8 enabling write keeps request", vecOut, bit64(9));
    irqIn[1] = 1'b1;
    tick(1);
    check("R5 slot rise preempts held request", vecOut, bit64(1));
    irqIn[1] = 1'b0;
    tick(1);
  endtask

  task automatic t_groupClear;
    busWrite(16'h1440, 32'h0);
    check("R7 clear of other group ignored", vecOut, bit64(1));
    busWrite(16'h1410, 32'h0);
    check("R9 gap cycle after group clear", vecOut, 64'h0);
    tick(1);
    check("R9 rescan finds pending board line", vecOut, bit64(63));
  endtask

  task automatic t_boardClear;
    busWrite(16'h18F0, 32'h0);
    check("R7 board clear of other line ignored", vecOut, bit64(63));
    busWrite(16'h18F8, 32'h0);
    check("R7 exact board clear retires", vecOut, 64'h0);
    tick(1);
    check("R9 still-pending line returns", vecOut, bit64(63));
    irqIn[63] = 1'b0;
    tick(1);
    busWrite(16'h18F8, 32'h0);
    tick(2);
    check("R9 rescan with nothing pending stays idle", vecOut, 64'h0);
  endtask

  task automatic t_scanOrder;
    irqIn[9] = 1'b1;
    tick(1);
    check("R5 request from line 9", vecOut, bit64(9));
    busWrite(16'h1018, 32'h8000_0000);
    busWrite(16'h1040, 32'h8000_0000);
    irqIn[35] = 1'b1;
    irqIn[40] = 1'b1;
    tick(1);
    irqIn[22] = 1'b1;
    tick(1);
    check("R1 disabled group 5 rise ignored", vecOut, bit64(9));
    busWrite(16'h0C28, 32'h8000_0000);
    tick(1);
    check("R5 enabling alone makes no request", vecOut, bit64(9));
    irqIn[9] = 1'b0;
    busWrite(16'h1440, 32'h0);
    check("R7 group 2 clear retires line 9", vecOut, 64'h0);
    tick(1);
    check("R9 slot line scanned before board lines", vecOut, bit64(22));
    irqIn[22] = 1'b0;
    busWrite(16'h14A0, 32'h0);
    tick(1);
    check("R9 lowest board line chosen", vecOut, bit64(35));
  endtask

  task automatic t_drop;
    busWrite(16'h1018, 32'h0000_0000);
    check("R8 disabling owner board map retires", vecOut, 64'h0);
    tick(1);
    check("R9 rescan after drop", vecOut, bit64(40));
    busWrite(16'h1040, 32'h7FFF_FFFF);
    tick(1);
    check("R8 drop with low bits set, nothing enabled", vecOut, 64'h0);
    irqIn[35] = 1'b0;
    irqIn[40] = 1'b0;
    tick(1);
    irqIn[9] = 1'b1;
    tick(1);
    check("R5 line 9 request again", vecOut, bit64(9));
    busWrite(16'h0C10, 32'h0);
    check("R8 disabling owner slot map retires", vecOut, 64'h0);
    tick(1);
    check("R8 stays idle after slot drop", vecOut, 64'h0);
    irqIn[9] = 1'b0;
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    busRead(16'hF000, d);
    check("R11 unmapped read zero", 64'(d), 64'h0);
    busRead(16'h1400, d);
    check("R11 clear register reads zero", 64'(d), 64'h0);
    busWrite(16'h0C40, 32'hFFFF_FFFF);
    busRead(16'h0C40, d);
    check("R11 read past slot maps zero", 64'(d), 64'h0);
    busRead(16'h0C38, d);
    check("R11 unmapped write leaves slot map 7", 64'(d), 64'h7DC);
    check("R11 unmapped write leaves vector idle", vecOut, 64'h0);
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(3);
    t_reset();
    t_mapWrite();
    t_disabled();
    t_slotRise();
    t_boardHeldBack();
    t_preempt();
    t_groupClear();
    t_boardClear();
    t_scanOrder();
    t_drop();
    t_unmapped();
    tick(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule